// File: doc/BRIEF.md
# Macro Program Sequencer with Delay Slots

This block is the control half of a small macro engine. It walks a program held in an external macro memory, and the ALU and result routing sit outside it. A one-cycle `start` pulse loads a base offset and resets the program counter to zero. From then on the sequencer issues word fetches at base plus program counter through a synchronous read port. It decodes each returned word and then chooses the next address. Instructions meant for the datapath are marked with `exec_valid`. Branches are resolved inside the block against a register value `reg_val` that the datapath supplies during the branch's execute cycle.

Control flow follows delayed-branch rules. A taken branch normally lets the next sequential word run as a delay slot before control moves to the target. With the annul bit set, control goes straight to the target. An exit mark also has a delay slot: the following word still runs, then the sequencer finishes with a `done` pulse. Three cases halt execution and raise `error` until the next start: a branch placed in a delay slot, the invalid operation code, and a fetch address past the memory depth.

The state machine has five states. IDLE waits for `start`. FETCH drives the read strobe for one cycle. EXEC sees the returned word, decodes it and chooses the next step. FINISH gives a one-cycle done pulse. FAULT holds the error. The transitions are:
- IDLE or FAULT to FETCH on `start`.
- FETCH to EXEC when the address is in range; FETCH to FAULT when it is not.
- EXEC to FETCH for the next instruction.
- EXEC to FINISH after the delay slot of an exit.
- EXEC to FAULT on an illegal word.
- FINISH to IDLE unconditionally.

Every instruction therefore takes two cycles.

Top module: `macro_seq`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `error`, `exec_valid` and `mem_rd` are all low.
- R2: A `start` pulse seen in IDLE or FAULT captures `start_base`. The next cycle fetches at `start_base` (program counter zero). Each instruction uses one fetch cycle (`mem_rd` high, `mem_addr` = base + pc) and then one execute cycle, and `busy` is high in both.
- R3: `exec_valid` is high in the execute cycle of every word whose operation field (bits 2:0) is 0 to 5. It stays low for branches (code 7).
- R4: A branch tests `reg_val` according to bit 4: 0 means taken when `reg_val` is zero, 1 means taken when it is nonzero. A branch that is not taken continues at pc + 1.
- R5: A taken branch with bit 5 clear executes exactly one further word, at pc + 1, and then continues at the branch's own pc plus the sign-extended word offset in bits 31:14.
- R6: A taken branch with bit 5 set skips the delay slot and fetches the target next.
- R7: A word with bit 7 set that is not in a delay slot lets the next sequential word execute. After that, `done` is high for exactly one cycle and `busy` falls.
- R8: Bit 7 on a word executing in a delay slot has no effect.
- R9: A branch word in a delay slot raises `error`, stops fetching, and keeps `error` high until the next `start`.
- R10: Operation code 6 raises `error` and halts, with no `exec_valid`.
- R11: When base + pc reaches the memory depth, no read is issued and `error` is raised.
- R12: `start` is ignored while `busy`. A `start` from FAULT clears `error` and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| start_base | input | AW | Program base word address |
| reg_val | input | RW | Register value tested by a branch in its execute cycle |
| mem_data | input | 32 | Instruction word, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe to macro memory |
| mem_addr | output | AW | Fetch word address |
| exec_valid | output | 1 | Datapath instruction present on `mem_data` |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Halted on illegal word or address |

## Verification
A corrupted program counter, or a lost delay-slot or redirect flag, shows up on `mem_addr` at the very next fetch, which is at most two cycles after the faulty execute cycle. The reference model compares that address on every clock. A wrong pending-exit flag shows up as `done` arriving one instruction early or late. A wrong fault decision shows up as `error` in the cycle after the offending execute. Per-run lists of executed addresses check the delay-slot and annul orderings directly.

// File: rtl/msq_pkg.sv
package msq_pkg;
    localparam int INSTR_W = 32;
    localparam int IMM_W   = 18;

    localparam logic [2:0] OP_INVALID = 3'd6;
    localparam logic [2:0] OP_JUMP    = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_FINISH,
        ST_FAULT
    } seq_state_t;

    typedef struct packed {
        logic              is_jump;
        logic              is_invalid;
        logic              test_nonzero;
        logic              skip_slot;
        logic              exit_mark;
        logic [IMM_W-1:0]  offset;
    } ctl_word_t;
endpackage

// File: rtl/msq_decode.sv
module msq_decode
    import msq_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output ctl_word_t          ctl
);
    always_comb begin
        ctl.is_jump      = (word[2:0] == OP_JUMP);
        ctl.is_invalid   = (word[2:0] == OP_INVALID);
        ctl.test_nonzero = word[4];
        ctl.skip_slot    = word[5];
        ctl.exit_mark    = word[7];
        ctl.offset       = word[31:14];
    end
endmodule

// File: rtl/msq_branch.sv
module msq_branch
    import msq_pkg::*;
#(
    parameter int AW = 6,
    parameter int RW = 32
) (
    input  ctl_word_t       ctl,
    input  logic [RW-1:0]   reg_val,
    input  logic [AW-1:0]   pc,
    output logic            taken,
    output logic [AW-1:0]   target
);
    logic [31:0] offset_ext;
    logic        is_zero;

    always_comb begin
        offset_ext = 32'($signed(ctl.offset));
        is_zero    = (reg_val == '0);
        taken      = ctl.is_jump && (ctl.test_nonzero ? !is_zero : is_zero);
        target     = pc + offset_ext[AW-1:0];
    end
endmodule

// File: rtl/msq_addr.sv
module msq_addr #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] addr,
    output logic          in_range
);
    logic [AW:0] sum;

    always_comb begin
        sum      = {1'b0, base} + {1'b0, pc};
        addr     = sum[AW-1:0];
        in_range = (sum < (AW+1)'(DEPTH));
    end
endmodule

// File: rtl/macro_seq.sv
module macro_seq
    import msq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int RW    = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      start_base,
    input  logic [RW-1:0]      reg_val,
    input  logic [INSTR_W-1:0] mem_data,
    output logic               mem_rd,
    output logic [AW-1:0]      mem_addr,
    output logic               exec_valid,
    output logic               busy,
    output logic               done,
    output logic               error
);
    seq_state_t    state_q, state_d;
    logic [AW-1:0] pc_q, pc_d, base_q, base_d, tgt_q, tgt_d;
    logic          slot_q, slot_d, redir_q, redir_d, exit_q, exit_d;

    ctl_word_t     ctl;
    logic          taken;
    logic [AW-1:0] target;
    logic          in_range;
    logic [AW-1:0] pc_inc;

    msq_decode u_dec (.word(mem_data), .ctl(ctl));

    msq_branch #(.AW(AW), .RW(RW)) u_br (
        .ctl(ctl), .reg_val(reg_val), .pc(pc_q), .taken(taken), .target(target)
    );

    msq_addr #(.DEPTH(DEPTH), .AW(AW)) u_addr (
        .base(base_q), .pc(pc_q), .addr(mem_addr), .in_range(in_range)
    );

    assign pc_inc = pc_q + AW'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            base_q  <= '0;
            tgt_q   <= '0;
            slot_q  <= 1'b0;
            redir_q <= 1'b0;
            exit_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            base_q  <= base_d;
            tgt_q   <= tgt_d;
            slot_q  <= slot_d;
            redir_q <= redir_d;
            exit_q  <= exit_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        base_d  = base_q;
        tgt_d   = tgt_q;
        slot_d  = slot_q;
        redir_d = redir_q;
        exit_d  = exit_q;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (start) begin
                    state_d = ST_FETCH;
                    base_d  = start_base;
                    pc_d    = '0;
                    slot_d  = 1'b0;
                    redir_d = 1'b0;
                    exit_d  = 1'b0;
                end
            end
            ST_FETCH: begin
                state_d = in_range ? ST_EXEC : ST_FAULT;
            end
            ST_EXEC: begin
                if (ctl.is_invalid || (ctl.is_jump && slot_q)) begin
                    state_d = ST_FAULT;
                end else if (taken && ctl.skip_slot) begin
                    pc_d    = target;
                    state_d = ST_FETCH;
                end else if (taken) begin
                    pc_d    = pc_inc;
                    slot_d  = 1'b1;
                    redir_d = 1'b1;
                    tgt_d   = target;
                    state_d = ST_FETCH;
                end else if (slot_q) begin
                    slot_d  = 1'b0;
                    redir_d = 1'b0;
                    exit_d  = 1'b0;
                    if (exit_q) begin
                        state_d = ST_FINISH;
                    end else begin
                        pc_d    = redir_q ? tgt_q : pc_inc;
                        state_d = ST_FETCH;
                    end
                end else if (ctl.exit_mark) begin
                    pc_d    = pc_inc;
                    slot_d  = 1'b1;
                    exit_d  = 1'b1;
                    state_d = ST_FETCH;
                end else begin
                    pc_d    = pc_inc;
                    state_d = ST_FETCH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q == ST_FETCH) || (state_q == ST_EXEC);
        mem_rd     = (state_q == ST_FETCH) && in_range;
        exec_valid = (state_q == ST_EXEC) && !ctl.is_jump && !ctl.is_invalid;
        done       = (state_q == ST_FINISH);
        error      = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/macro_seq_chk.sv
module macro_seq_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] start_base,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          exec_valid,
    input logic          busy,
    input logic          done,
    input logic          error
);
    // R2: first fetch of a run uses the captured base
    assert_first_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_addr == $past(start_base)));

    // R2: a fetch cycle is always followed by a non-fetch cycle
    assert_fetch_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R3: an executed word was read in the cycle before
    assert_exec_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> $past(mem_rd));

    // R7: done is a single pulse while not running
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: error holds until a new start
    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R12: running only begins on start
    assert_busy_needs_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

bind macro_seq macro_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .exec_valid(exec_valid),
    .busy(busy), .done(done), .error(error)
);

// File: tb/macro_seq_test.sv
`timescale 1ns/1ps
module macro_seq_test;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int MASK  = DEPTH - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [AW-1:0] start_base = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] mem_data = '0;
    logic        mem_rd, exec_valid, busy, done, error;
    logic [AW-1:0] mem_addr;

    logic [31:0] mem [DEPTH];

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    macro_seq #(.DEPTH(DEPTH), .RW(32)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
        .reg_val(reg_val), .mem_data(mem_data), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .exec_valid(exec_valid), .busy(busy),
        .done(done), .error(error)
    );

    always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input bit c, input bit an,
                                       input bit ex, input int imm);
        logic [17:0] i18;
        i18 = imm[17:0];
        return {i18, 6'd0, ex, 1'b0, an, c, 1'b0, op[2:0]};
    endfunction

    // behavioural reference model: 0 idle, 1 fetch, 2 exec, 3 finish, 4 fault
    int mst = 0, mbase = 0, mpc = 0, mtgt = 0;
    bit mslot = 0, mred = 0, mex = 0;
    logic [31:0] mins = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mpc = 0; mbase = 0; mslot = 0; mred = 0; mex = 0;
        end else begin
            case (mst)
                0, 4: if (start) begin
                    mst = 1; mbase = int'(start_base); mpc = 0;
                    mslot = 0; mred = 0; mex = 0;
                end
                1: if (mbase + mpc >= DEPTH) mst = 4;
                   else begin mins = mem[mbase + mpc]; mst = 2; end
                2: begin
                    int op, tg;
                    bit tk;
                    op = int'(mins[2:0]);
                    tk = (op == 7) && (mins[4] ? (reg_val != 0) : (reg_val == 0));
                    tg = (mpc + int'($signed(mins[31:14]))) & MASK;
                    if (op == 6 || (op == 7 && mslot)) mst = 4;
                    else if (tk && mins[5]) begin mpc = tg; mst = 1; end
                    else if (tk) begin mpc = (mpc + 1) & MASK; mslot = 1; mred = 1; mtgt = tg; mst = 1; end
                    else if (mslot) begin
                        if (mex) mst = 3;
                        else begin mpc = mred ? mtgt : ((mpc + 1) & MASK); mst = 1; end
                        mslot = 0; mred = 0; mex = 0;
                    end
                    else if (mins[7]) begin mpc = (mpc + 1) & MASK; mslot = 1; mex = 1; mst = 1; end
                    else begin mpc = (mpc + 1) & MASK; mst = 1; end
                end
                3: mst = 0;
                default: mst = 0;
            endcase
        end
    end

    // per-cycle comparison and trace capture
    int  got[$];
    int  last_addr = 0;
    bit  done_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_rd;
            e_rd = (mst == 1) && (mbase + mpc < DEPTH);
            check(busy == (mst == 1 || mst == 2), "R2 busy", busy, (mst == 1 || mst == 2));
            check(mem_rd == e_rd, "R2 mem_rd", mem_rd, e_rd);
            if (e_rd) check(int'(mem_addr) == ((mbase + mpc) & MASK), "R2 mem_addr",
                            mem_addr, (mbase + mpc) & MASK);
            check(exec_valid == (mst == 2 && mins[2:0] < 3'd6), "R3 exec_valid",
                  exec_valid, (mst == 2 && mins[2:0] < 3'd6));
            check(done == (mst == 3), "R7 done", done, (mst == 3));
            check(error == (mst == 4), "R9 error", error, (mst == 4));
            if (mem_rd) last_addr = int'(mem_addr);
            if (exec_valid) got.push_back(last_addr);
            if (done) done_seen = 1;
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = mk(6, 0, 0, 0, 0);
    endtask

    task automatic run(input int base, input int rv, input int exp[$], input bit exp_err,
                       input bit poke, input string req);
        reg_val = 32'(rv);
        @(negedge clk);
        got.delete();
        done_seen = 0;
        start = 1'b1;
        start_base = AW'(base);
        @(negedge clk);
        start = 1'b0;
        #1;
        check(error == 1'b0, "R12 error cleared by start", error, 0);
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (poke && n == 2) begin start = 1'b1; start_base = AW'(50); end
            if (poke && n == 3) start = 1'b0;
            #1;
            if (done_seen || error) break;
        end
        check(got.size() == exp.size(), {req, " executed count"}, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            check(got[i] == exp[i], {req, " executed address"}, got[i], exp[i]);
        check(error == exp_err, {req, " error flag"}, error, exp_err);
        check(done_seen == !exp_err, {req, " done seen"}, done_seen, !exp_err);
        @(negedge clk);
        check(busy == 1'b0, {req, " busy low at end"}, busy, 0);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int none[$];
        clear_mem();
        repeat (3) @(negedge clk);
        // R1: reset values
        check({busy, done, error, exec_valid, mem_rd} == 5'b0, "R1 reset outputs",
              {busy, done, error, exec_valid, mem_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, error, exec_valid, mem_rd} == 5'b0, "R1 after reset",
              {busy, done, error, exec_valid, mem_rd}, 0);

        // R2 R3 R7 R12: straight line with exit, extra start while busy
        mem[10] = mk(1, 0, 0, 0, 0);
        mem[11] = mk(0, 0, 0, 1, 0);
        mem[12] = mk(5, 0, 0, 0, 0);
        run(10, 0, '{10, 11, 12}, 0, 1, "R7 exit slot / R12 start ignored");

        // R4 R5: taken on zero with delay slot
        clear_mem();
        mem[0] = mk(0, 0, 0, 0, 0);
        mem[1] = mk(7, 0, 0, 0, 3);
        mem[2] = mk(2, 0, 0, 0, 0);
        mem[4] = mk(0, 0, 0, 1, 0);
        mem[5] = mk(3, 0, 0, 0, 0);
        run(0, 0, '{0, 2, 4, 5}, 0, 0, "R5 delay slot");

        // R6: annulled taken branch at an offset base
        clear_mem();
        mem[20] = mk(0, 0, 0, 0, 0);
        mem[21] = mk(7, 0, 1, 0, 3);
        mem[22] = mk(2, 0, 0, 0, 0);
        mem[24] = mk(0, 0, 0, 1, 0);
        mem[25] = mk(3, 0, 0, 0, 0);
        run(20, 0, '{20, 24, 25}, 0, 0, "R6 annul");

        // R4: nonzero test on zero value falls through
        clear_mem();
        mem[30] = mk(7, 1, 0, 0, 5);
        mem[31] = mk(0, 0, 0, 1, 0);
        mem[32] = mk(1, 0, 0, 0, 0);
        run(30, 0, '{31, 32}, 0, 0, "R4 not taken");

        // R4 R5: nonzero taken, forward then backward offset
        clear_mem();
        mem[40] = mk(7, 1, 1, 0, 3);
        mem[43] = mk(7, 1, 1, 0, -2);
        mem[41] = mk(0, 0, 0, 1, 0);
        mem[42] = mk(4, 0, 0, 0, 0);
        run(40, 5, '{41, 42}, 0, 0, "R4 nonzero taken backward");

        // R8: exit mark inside a branch delay slot ignored
        clear_mem();
        mem[0] = mk(7, 0, 0, 0, 3);
        mem[1] = mk(1, 0, 0, 1, 0);
        mem[3] = mk(0, 0, 0, 0, 0);
        mem[4] = mk(0, 0, 0, 1, 0);
        mem[5] = mk(0, 0, 0, 0, 0);
        run(0, 0, '{1, 3, 4, 5}, 0, 0, "R8 exit in slot");

        // R9: branch in exit delay slot
        clear_mem();
        mem[0] = mk(0, 0, 0, 1, 0);
        mem[1] = mk(7, 0, 0, 0, 2);
        run(0, 0, '{0}, 1, 0, "R9 branch in slot");
        repeat (3) @(negedge clk);
        check(error == 1'b1, "R9 error held", error, 1);

        // R10 R12: invalid opcode, started from fault
        clear_mem();
        run(8, 0, none, 1, 0, "R10 invalid op");

        // R11: run past memory end
        clear_mem();
        mem[62] = mk(0, 0, 0, 0, 0);
        mem[63] = mk(1, 0, 0, 0, 0);
        run(62, 0, '{62, 63}, 1, 0, "R11 range");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule